// File: doc/BRIEF.md
# Indirect Flash Transfer Engine

This block moves bulk data between a host and a serial flash without the host driving each flash access. Software programs a start address and a byte count for a direction, then sets that direction's start bit. On a read, the engine asks a flash-side byte mover for consecutive bytes, packs them into 32-bit words and queues them in the read half of an internal word buffer. The host pops them through the buffer port. On a write, the host pushes words or single bytes into the write half, and the engine unpacks them and hands each byte to the mover.

The word buffer is a single array divided by a split register into a read ring and a write ring. A level register reports how many words each ring holds. Each direction has its own control word carrying start, cancel, busy and done. Done is cleared by writing one to it. Only one flash request is open at a time. The read direction wins a free port, but a request that has not yet been answered keeps its direction.

Top module: `itx_engine`

## Requirements
- R1: After reset both control words and the level register read 0, the split register reads DEPTH/2, and `fl_req` is low.
- R2: Register indices: 0 read control, 1 read start address, 2 read byte count, 3 write control, 4 write start address, 5 write byte count, 6 level, 7 split. In a control word, bit 0 starts the transfer, bit 1 cancels it, bit 2 reads as busy, and bit 5 reads as done. Writing 1 to bit 5 clears done.
- R3: A started transfer issues exactly one flash request per byte, at consecutive addresses from the programmed start address. A count of 0 sets done without any request. `fl_req` is never high while both directions are idle.
- R4: The level register holds the read-ring fill in bits 15:0 and the write-ring fill in bits 31:16, both counted in 32-bit words.
- R5: Read bytes are packed little-endian: byte k of the transfer goes to bits 8*(k mod 4)+7:8*(k mod 4). A final partial word is queued with its unused upper bytes zero.
- R6: The read ring never holds more words than the split value. No read request is raised while it is full, and requests resume once the host pops a word.
- R7: No write request is raised while the write ring is empty. The bytes of each queued word go out in little-endian order (bits 7:0 first).
- R8: Busy and done are never both set. On the clock edge that accepts the final byte, busy falls and done rises together.
- R9: Cancel clears busy and leaves done clear. It empties that direction's ring, and no further request for that transfer is issued.
- R10: With `hb_byte` high, a host read returns the next byte zero-extended and pops the word after its fourth byte or after the transfer's last byte. A host byte write is packed little-endian and queued when the word fills or the transfer's last byte arrives.
- R11: The split register accepts a value only when it lies in 1..DEPTH-1 and both directions are idle. An accepted write empties both rings. The read ring then holds the split value in words and the write ring holds the rest of the buffer.
- R12: When both directions can issue, the read request is presented. A request left unanswered in one cycle keeps its direction in the next cycle while that direction can still issue.
- R13: While a direction is busy, writes to its start address, its byte count and its start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| hb_rd | input | 1 | Host pop from the read ring |
| hb_wr | input | 1 | Host push to the write ring |
| hb_byte | input | 1 | Host access is a single byte |
| hb_wdata | input | 32 | Host write data (bits 7:0 for byte access) |
| hb_rdata | output | 32 | Head word, or head byte zero-extended |
| fl_req | output | 1 | Flash byte request valid |
| fl_wr | output | 1 | Request is a write (1) or a read (0) |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 8 | Byte to write |
| fl_ack | input | 1 | Mover accepts the request this cycle |
| fl_rdata | input | 8 | Read byte, valid with `fl_ack` on a read |

## Verification
The assertions check several properties on every cycle: busy and done never overlap, the read ring stays within its share, no read request is made into a full ring and no write request from an empty one, and an unanswered read request holds its direction. They also check that the last accepted byte raises done on the next edge and that a cancel drops busy. Byte ordering, zero padding of a short final word, resumption after host pops, ignored reprogramming while busy, split-write rules and the exact request order under contention can only be shown by the bench. It compares every mover handshake and host pop against values derived from the requirements.

// File: rtl/itx_pkg.sv
package itx_pkg;

    localparam int unsigned CTL_START  = 0;
    localparam int unsigned CTL_CANCEL = 1;
    localparam int unsigned CTL_BUSY   = 2;
    localparam int unsigned CTL_DONE   = 5;

    typedef enum logic [2:0] {
        RG_RD_CTL  = 3'd0,
        RG_RD_ADDR = 3'd1,
        RG_RD_CNT  = 3'd2,
        RG_WR_CTL  = 3'd3,
        RG_WR_ADDR = 3'd4,
        RG_WR_CNT  = 3'd5,
        RG_LEVEL   = 3'd6,
        RG_SPLIT   = 3'd7
    } itx_reg_e;

    typedef struct packed {
        logic start;
        logic cancel;
        logic clr_done;
    } itx_cmd_t;

    function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [1:0] lane,
                                             input logic [7:0] b);
        logic [31:0] r;
        r = w;
        r[{lane, 3'b000} +: 8] = b;
        return r;
    endfunction

    function automatic logic [7:0] lane_get(input logic [31:0] w, input logic [1:0] lane);
        return w[{lane, 3'b000} +: 8];
    endfunction

    function automatic logic [31:0] ctl_word(input logic busy, input logic done);
        logic [31:0] r;
        r = '0;
        r[CTL_BUSY] = busy;
        r[CTL_DONE] = done;
        return r;
    endfunction

endpackage

// File: rtl/itx_dir_seq.sv
module itx_dir_seq
    import itx_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  itx_cmd_t      cmd,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_cnt,
    input  logic          beat,
    output logic          busy,
    output logic          done,
    output logic          last,
    output logic [AW-1:0] cur_addr
);
    logic [CW-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            rem      <= '0;
            cur_addr <= '0;
        end else begin
            if (cmd.clr_done) done <= 1'b0;
            if (busy) begin
                if (cmd.cancel) begin
                    busy <= 1'b0;
                end else if (beat) begin
                    rem      <= rem - CW'(1);
                    cur_addr <= cur_addr + AW'(1);
                    if (rem == CW'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end else if (cmd.start && !cmd.cancel) begin
                cur_addr <= cfg_addr;
                rem      <= cfg_cnt;
                if (cfg_cnt == '0) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    done <= 1'b0;
                end
            end
        end
    end

    assign last = (rem == CW'(1));
endmodule

// File: rtl/itx_split_buffer.sv
module itx_split_buffer #(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LW-1:0]       split,
    input  logic [1:0]          flush,
    input  logic [1:0]          push,
    input  logic [1:0]          pop,
    input  logic [1:0][31:0]    wdata,
    output logic [1:0][31:0]    head,
    output logic [1:0][LW-1:0]  lvl
);
    logic [31:0]          mem [DEPTH];
    logic [1:0][PW-1:0]   wsel;
    logic [1:0][LW-1:0]   lo;
    logic [1:0][LW-1:0]   hi;

    assign lo[0] = '0;
    assign hi[0] = split;
    assign lo[1] = split;
    assign hi[1] = LW'(DEPTH);

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [LW-1:0] l,
                                           input logic [LW-1:0] h);
        logic [LW-1:0] n;
        n = LW'(p) + LW'(1);
        return (n == h) ? PW'(l) : PW'(n);
    endfunction

    for (genvar g = 0; g < 2; g++) begin : g_ring
        localparam logic [PW-1:0] RST_LO = (g == 0) ? '0 : PW'(DEPTH / 2);
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [LW-1:0] lv;

        always_ff @(posedge clk) begin
            if (rst) begin
                wp <= RST_LO;
                rp <= RST_LO;
                lv <= '0;
            end else if (flush[g]) begin
                wp <= PW'(lo[g]);
                rp <= PW'(lo[g]);
                lv <= '0;
            end else begin
                if (push[g]) wp <= step(wp, lo[g], hi[g]);
                if (pop[g])  rp <= step(rp, lo[g], hi[g]);
                lv <= lv + LW'(push[g]) - LW'(pop[g]);
            end
        end

        assign wsel[g] = wp;
        assign lvl[g]  = lv;
        assign head[g] = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (push[0]) mem[wsel[0]] <= wdata[0];
        if (push[1]) mem[wsel[1]] <= wdata[1];
    end
endmodule

// File: rtl/itx_engine.sv
module itx_engine
    import itx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int CW    = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wen,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          hb_rd,
    input  logic          hb_wr,
    input  logic          hb_byte,
    input  logic [31:0]   hb_wdata,
    output logic [31:0]   hb_rdata,
    output logic          fl_req,
    output logic          fl_wr,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    input  logic          fl_ack,
    input  logic [7:0]    fl_rdata
);
    itx_reg_e ridx;
    assign ridx = itx_reg_e'(reg_addr);

    // configuration
    logic [AW-1:0] rd_addr_q, wr_addr_q;
    logic [CW-1:0] rd_cnt_q, wr_cnt_q;
    logic [LW-1:0] split_q;

    // sequencer outputs
    logic rd_busy, rd_done, rd_last, wr_busy, wr_done, wr_last;
    logic [AW-1:0] rd_cur, wr_cur;
    itx_cmd_t rd_cmd, wr_cmd;

    // buffer interface
    logic [1:0]          b_flush, b_push, b_pop;
    logic [1:0][31:0]    b_wdata, b_head;
    logic [1:0][LW-1:0]  b_lvl;
    logic [LW-1:0]       r_lvl, w_lvl;

    // host and packing state
    logic [CW-1:0] rd_hleft, wr_hleft;
    logic [1:0]    rd_hlane, rd_plane, wr_plane, wr_dlane;
    logic [31:0]   rd_pack, wr_pack;

    // arbitration
    logic hold_v, hold_wr, rd_want, wr_want, sel_wr, rd_beat, wr_beat;
    logic split_ld, start_r, start_w, flush_r, flush_w;
    logic hr_ok, hr_pop, hw_ok, hw_push;

    logic hit_rctl, hit_wctl;
    assign hit_rctl = reg_wen && (ridx == RG_RD_CTL);
    assign hit_wctl = reg_wen && (ridx == RG_WR_CTL);

    assign rd_cmd = '{start: hit_rctl & reg_wdata[CTL_START], cancel: hit_rctl & reg_wdata[CTL_CANCEL],
                      clr_done: hit_rctl & reg_wdata[CTL_DONE]};
    assign wr_cmd = '{start: hit_wctl & reg_wdata[CTL_START], cancel: hit_wctl & reg_wdata[CTL_CANCEL],
                      clr_done: hit_wctl & reg_wdata[CTL_DONE]};

    assign split_ld = reg_wen && (ridx == RG_SPLIT) && !rd_busy && !wr_busy &&
                      (reg_wdata >= 32'd1) && (reg_wdata < 32'(DEPTH));
    assign start_r  = rd_cmd.start && !rd_cmd.cancel && !rd_busy;
    assign start_w  = wr_cmd.start && !wr_cmd.cancel && !wr_busy;
    assign flush_r  = rd_cmd.cancel || start_r || split_ld;
    assign flush_w  = wr_cmd.cancel || start_w || split_ld;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            rd_cnt_q  <= '0;
            wr_cnt_q  <= '0;
            split_q   <= LW'(DEPTH / 2);
        end else if (reg_wen) begin
            if (ridx == RG_RD_ADDR && !rd_busy) rd_addr_q <= reg_wdata[AW-1:0];
            if (ridx == RG_RD_CNT  && !rd_busy) rd_cnt_q  <= reg_wdata[CW-1:0];
            if (ridx == RG_WR_ADDR && !wr_busy) wr_addr_q <= reg_wdata[AW-1:0];
            if (ridx == RG_WR_CNT  && !wr_busy) wr_cnt_q  <= reg_wdata[CW-1:0];
            if (split_ld) split_q <= reg_wdata[LW-1:0];
        end
    end

    itx_dir_seq #(.AW(AW), .CW(CW)) u_rd_seq (
        .clk(clk), .rst(rst), .cmd(rd_cmd), .cfg_addr(rd_addr_q), .cfg_cnt(rd_cnt_q),
        .beat(rd_beat), .busy(rd_busy), .done(rd_done), .last(rd_last), .cur_addr(rd_cur)
    );

    itx_dir_seq #(.AW(AW), .CW(CW)) u_wr_seq (
        .clk(clk), .rst(rst), .cmd(wr_cmd), .cfg_addr(wr_addr_q), .cfg_cnt(wr_cnt_q),
        .beat(wr_beat), .busy(wr_busy), .done(wr_done), .last(wr_last), .cur_addr(wr_cur)
    );

    itx_split_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .split(split_q), .flush(b_flush), .push(b_push), .pop(b_pop),
        .wdata(b_wdata), .head(b_head), .lvl(b_lvl)
    );

    assign r_lvl   = b_lvl[0];
    assign w_lvl   = b_lvl[1];
    assign b_flush = {flush_w, flush_r};

    // flash-side arbitration: read first, an unanswered request keeps its side
    assign rd_want  = rd_busy && (r_lvl < split_q);
    assign wr_want  = wr_busy && (w_lvl != '0);
    assign sel_wr   = (hold_v && hold_wr && wr_want) || !rd_want;
    assign fl_req   = rd_want || wr_want;
    assign fl_wr    = sel_wr;
    assign fl_addr  = sel_wr ? wr_cur : rd_cur;
    assign fl_wdata = lane_get(b_head[1], wr_dlane);
    assign rd_beat  = fl_req && fl_ack && !sel_wr;
    assign wr_beat  = fl_req && fl_ack && sel_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v  <= 1'b0;
            hold_wr <= 1'b0;
        end else begin
            hold_v  <= fl_req && !fl_ack;
            hold_wr <= sel_wr;
        end
    end

    // read ring: engine pushes packed words, host pops
    assign b_push[0]  = rd_beat && (rd_plane == 2'd3 || rd_last);
    assign b_wdata[0] = lane_put(rd_pack, rd_plane, fl_rdata);
    assign hr_ok      = hb_rd && (r_lvl != '0);
    assign hr_pop     = hr_ok && (!hb_byte || rd_hlane == 2'd3 || rd_hleft <= CW'(1));
    assign b_pop[0]   = hr_pop;
    assign hb_rdata   = (r_lvl == '0) ? '0 :
                        hb_byte ? {24'd0, lane_get(b_head[0], rd_hlane)} : b_head[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hleft <= '0;
            rd_hlane <= '0;
            rd_pack  <= '0;
            rd_plane <= '0;
        end else begin
            if (start_r)      rd_hleft <= rd_cnt_q;
            else if (flush_r) rd_hleft <= '0;
            else if (hr_ok) begin
                if (hb_byte)                  rd_hleft <= (rd_hleft != '0) ? rd_hleft - CW'(1) : '0;
                else if (rd_hleft > CW'(4))   rd_hleft <= rd_hleft - CW'(4);
                else                          rd_hleft <= '0;
            end
            if (flush_r) begin
                rd_hlane <= '0;
                rd_pack  <= '0;
                rd_plane <= '0;
            end else begin
                if (hr_ok) rd_hlane <= hr_pop ? 2'd0 : rd_hlane + 2'd1;
                if (rd_beat) begin
                    rd_pack  <= b_push[0] ? '0 : b_wdata[0];
                    rd_plane <= b_push[0] ? 2'd0 : rd_plane + 2'd1;
                end
            end
        end
    end

    // write ring: host pushes, engine drains byte by byte
    assign hw_ok      = hb_wr && (wr_hleft != '0) && (w_lvl < (LW'(DEPTH) - split_q));
    assign hw_push    = hw_ok && (!hb_byte || wr_plane == 2'd3 || wr_hleft == CW'(1));
    assign b_push[1]  = hw_push;
    assign b_wdata[1] = hb_byte ? lane_put(wr_pack, wr_plane, hb_wdata[7:0]) : hb_wdata;
    assign b_pop[1]   = wr_beat && (wr_dlane == 2'd3 || wr_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_hleft <= '0;
            wr_pack  <= '0;
            wr_plane <= '0;
            wr_dlane <= '0;
        end else begin
            if (start_w)      wr_hleft <= wr_cnt_q;
            else if (flush_w) wr_hleft <= '0;
            else if (hw_ok) begin
                if (hb_byte)                wr_hleft <= wr_hleft - CW'(1);
                else if (wr_hleft > CW'(4)) wr_hleft <= wr_hleft - CW'(4);
                else                        wr_hleft <= '0;
            end
            if (flush_w) begin
                wr_pack  <= '0;
                wr_plane <= '0;
                wr_dlane <= '0;
            end else begin
                if (hw_ok && hb_byte) begin
                    wr_pack  <= hw_push ? '0 : b_wdata[1];
                    wr_plane <= hw_push ? 2'd0 : wr_plane + 2'd1;
                end
                if (wr_beat) wr_dlane <= b_pop[1] ? 2'd0 : wr_dlane + 2'd1;
            end
        end
    end

    always_comb begin
        case (ridx)
            RG_RD_CTL:  reg_rdata = ctl_word(rd_busy, rd_done);
            RG_RD_ADDR: reg_rdata = 32'(rd_addr_q);
            RG_RD_CNT:  reg_rdata = 32'(rd_cnt_q);
            RG_WR_CTL:  reg_rdata = ctl_word(wr_busy, wr_done);
            RG_WR_ADDR: reg_rdata = 32'(wr_addr_q);
            RG_WR_CNT:  reg_rdata = 32'(wr_cnt_q);
            RG_LEVEL:   reg_rdata = {16'(w_lvl), 16'(r_lvl)};
            default:    reg_rdata = 32'(split_q);
        endcase
    end
endmodule

// File: rtl/itx_engine_chk.sv
module itx_engine_chk #(
    parameter int LW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_busy,
    input logic          rd_done,
    input logic          wr_busy,
    input logic          wr_done,
    input logic          rd_last,
    input logic          rd_cancel,
    input logic [LW-1:0] r_lvl,
    input logic [LW-1:0] w_lvl,
    input logic [LW-1:0] split_q,
    input logic          fl_req,
    input logic          fl_wr,
    input logic          fl_ack
);
    p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(rd_busy && rd_done) && !(wr_busy && wr_done));

    p_done_on_last_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_busy && fl_req && fl_ack && !fl_wr && rd_last && !rd_cancel) |=> (rd_done && !rd_busy));

    p_read_within_share_r6: assert property (@(posedge clk) disable iff (rst)
        r_lvl <= split_q);

    p_no_read_into_full_r6: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !fl_wr) |-> (r_lvl < split_q));

    p_no_write_from_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (fl_req && fl_wr) |-> (w_lvl != '0));

    p_cancel_idles_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_cancel && rd_busy) |=> (!rd_busy && !rd_done));

    p_req_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
        fl_req |-> (rd_busy || wr_busy));

    p_read_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !fl_ack && !fl_wr && !rd_cancel) |=> (fl_req && !fl_wr));
endmodule

bind itx_engine itx_engine_chk #(.LW(LW)) u_chk (
    .clk(clk), .rst(rst), .rd_busy(rd_busy), .rd_done(rd_done), .wr_busy(wr_busy),
    .wr_done(wr_done), .rd_last(rd_last), .rd_cancel(rd_cmd.cancel), .r_lvl(r_lvl),
    .w_lvl(w_lvl), .split_q(split_q), .fl_req(fl_req), .fl_wr(fl_wr), .fl_ack(fl_ack)
);

// File: tb/itx_engine_test.sv
module itx_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hb_rd = 1'b0, hb_wr = 1'b0, hb_byte = 1'b0;
    logic [31:0] hb_wdata = '0;
    logic [31:0] hb_rdata;
    logic        fl_req, fl_wr;
    logic [31:0] fl_addr;
    logic [7:0]  fl_wdata;
    logic        fl_ack = 1'b0;
    logic [7:0]  fl_rdata = '0;

    always #10 clk = ~clk;

    itx_engine uut (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hb_rd(hb_rd), .hb_wr(hb_wr), .hb_byte(hb_byte),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .fl_req(fl_req), .fl_wr(fl_wr),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
    );

    int checks = 0;
    int fails  = 0;
    int acks   = 0;
    bit mover_on = 1'b0;

    typedef struct { bit wr; logic [31:0] addr; logic [7:0] data; } op_t;
    op_t expq[$];

    function automatic logic [7:0] fdat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] wexp(input logic [31:0] base, input int i, input int n);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 4; k++)
            if (4 * i + k < n) w[8*k +: 8] = fdat(base + 32'(4 * i + k));
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: answers the engine and compares each handshake with the scoreboard
    always @(negedge clk) begin
        #2;
        if (fl_req === 1'b1 && mover_on && !rst) begin
            fl_ack   = 1'b1;
            fl_rdata = fdat(fl_addr);
            acks++;
            if (expq.size() == 0) begin
                chk("R3 unexpected request", fl_addr, 32'hFFFF_FFFF);
            end else begin
                op_t e;
                e = expq.pop_front();
                chk("R3 R12 request kind", 32'(fl_wr), 32'(e.wr));
                chk("R3 request address", fl_addr, e.addr);
                if (e.wr) chk("R7 write byte", 32'(fl_wdata), 32'(e.data));
            end
        end else begin
            fl_ack = 1'b0;
        end
    end

    // driver tasks
    task automatic exp_reads(input logic [31:0] a, input int n);
        for (int i = 0; i < n; i++) expq.push_back('{1'b0, a + 32'(i), 8'h00});
    endtask

    task automatic exp_write(input logic [31:0] a, input logic [7:0] d);
        expq.push_back('{1'b1, a, d});
    endtask

    task automatic reg_wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 3'(idx); reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_rd(input int idx, output logic [31:0] v);
        reg_addr = 3'(idx);
        #1;
        v = reg_rdata;
    endtask

    task automatic host_rd(input bit b, output logic [31:0] v);
        @(negedge clk);
        hb_rd = 1'b1; hb_byte = b;
        #1;
        v = hb_rdata;
        @(negedge clk);
        hb_rd = 1'b0; hb_byte = 1'b0;
    endtask

    task automatic host_rd_wait(input bit b, output logic [31:0] v);
        logic [31:0] lv;
        for (int n = 0; n < 500; n++) begin
            reg_rd(6, lv);
            if (lv[15:0] != 0) break;
            @(negedge clk);
        end
        host_rd(b, v);
    endtask

    task automatic host_wr(input bit b, input logic [31:0] d);
        @(negedge clk);
        hb_wr = 1'b1; hb_byte = b; hb_wdata = d;
        @(negedge clk);
        hb_wr = 1'b0; hb_byte = 1'b0;
    endtask

    task automatic wait_done(input int idx, input string req);
        logic [31:0] v;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            reg_rd(idx, v);
            if (v === 32'h20) return;
            if (v !== 32'h4) begin
                chk(req, v, 32'h20);
                return;
            end
        end
        chk({req, " timeout"}, v, 32'h20);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int a0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_rd(0, v); chk("R1 read control", v, 32'h0);
        reg_rd(3, v); chk("R1 write control", v, 32'h0);
        reg_rd(6, v); chk("R1 level", v, 32'h0);
        reg_rd(7, v); chk("R1 split", v, 32'd8);
        chk("R1 no request", 32'(fl_req), 32'h0);

        // R3 R5 R8 R2: plain read of 10 bytes
        mover_on = 1'b1;
        reg_wr(1, 32'h100); reg_wr(2, 32'd10);
        exp_reads(32'h100, 10);
        reg_wr(0, 32'h1);
        wait_done(0, "R8 read busy/done");
        chk("R3 all reads issued", 32'(expq.size()), 32'd0);
        reg_rd(6, v); chk("R4 read level words", v, 32'd3);
        for (int i = 0; i < 3; i++) begin
            host_rd(1'b0, v);
            chk("R5 packed word", v, wexp(32'h100, i, 10));
        end
        reg_rd(0, v); chk("R2 done bit", v, 32'h20);
        reg_wr(0, 32'h20);
        reg_rd(0, v); chk("R2 done cleared by write-one", v, 32'h0);

        // R3 zero count
        a0 = acks;
        reg_wr(2, 32'd0); reg_wr(0, 32'h1);
        reg_rd(0, v); chk("R3 zero count done", v, 32'h20);
        wait_cyc(5);
        chk("R3 zero count no request", 32'(acks - a0), 32'd0);
        reg_wr(0, 32'h20);

        // R6 stall on full read share, resume on host pops
        a0 = acks;
        reg_wr(1, 32'h400); reg_wr(2, 32'd40);
        exp_reads(32'h400, 40);
        reg_wr(0, 32'h1);
        wait_cyc(60);
        reg_rd(6, v); chk("R6 read share full", v, 32'd8);
        chk("R6 no request when full", 32'(fl_req), 32'h0);
        chk("R6 bytes before stall", 32'(acks - a0), 32'd32);
        reg_rd(0, v); chk("R6 still busy", v, 32'h4);
        for (int i = 0; i < 10; i++) begin
            host_rd_wait(1'b0, v);
            chk("R6 resumed word", v, wexp(32'h400, i, 40));
        end
        wait_done(0, "R8 read after stall");
        reg_wr(0, 32'h20);

        // R10 byte reads
        reg_wr(1, 32'h500); reg_wr(2, 32'd6);
        exp_reads(32'h500, 6);
        reg_wr(0, 32'h1);
        wait_done(0, "R8 short read");
        for (int i = 0; i < 6; i++) begin
            host_rd(1'b1, v);
            chk("R10 byte read", v, {24'd0, fdat(32'h500 + 32'(i))});
            if (i == 3) begin reg_rd(6, v); chk("R10 pop after fourth byte", v, 32'd1); end
        end
        reg_rd(6, v); chk("R10 pop after last byte", v, 32'd0);
        reg_wr(0, 32'h20);

        // R7 R4 R10 write path
        mover_on = 1'b0;
        reg_wr(4, 32'h200); reg_wr(5, 32'd10); reg_wr(3, 32'h1);
        wait_cyc(5);
        chk("R7 no request while write share empty", 32'(fl_req), 32'h0);
        host_wr(1'b0, 32'h44332211);
        host_wr(1'b0, 32'h88776655);
        reg_rd(6, v); chk("R4 write level words", v, 32'h0002_0000);
        chk("R7 write request raised", 32'({fl_req, fl_wr}), 32'h3);
        host_wr(1'b1, 32'h99);
        host_wr(1'b1, 32'hAA);
        reg_rd(6, v); chk("R10 last byte queued", v, 32'h0003_0000);
        for (int i = 0; i < 8; i++) exp_write(32'h200 + 32'(i), 8'(8'h11 * (i + 1)));
        exp_write(32'h208, 8'h99);
        exp_write(32'h209, 8'hAA);
        mover_on = 1'b1;
        wait_done(3, "R8 write busy/done");
        chk("R7 all writes issued", 32'(expq.size()), 32'd0);
        reg_rd(6, v); chk("R7 write share drained", v, 32'h0);
        reg_wr(3, 32'h20);

        // R9 cancel
        reg_wr(1, 32'h600); reg_wr(2, 32'd100);
        exp_reads(32'h600, 32);
        reg_wr(0, 32'h1);
        wait_cyc(50);
        reg_wr(0, 32'h2);
        reg_rd(0, v); chk("R9 cancel idles without done", v, 32'h0);
        reg_rd(6, v); chk("R9 cancel empties read share", v, 32'h0);
        a0 = acks;
        wait_cyc(20);
        chk("R9 no request after cancel", 32'(acks - a0), 32'd0);
        chk("R9 scoreboard drained", 32'(expq.size()), 32'd0);

        // R13 reprogramming ignored while busy
        mover_on = 1'b0;
        reg_wr(1, 32'h700); reg_wr(2, 32'd8); reg_wr(0, 32'h1);
        reg_wr(2, 32'd3); reg_wr(1, 32'h900); reg_wr(0, 32'h1);
        reg_rd(2, v); chk("R13 count held", v, 32'd8);
        reg_rd(1, v); chk("R13 address held", v, 32'h700);
        exp_reads(32'h700, 8);
        a0 = acks;
        mover_on = 1'b1;
        wait_done(0, "R13 transfer");
        chk("R13 byte total", 32'(acks - a0), 32'd8);
        reg_wr(0, 32'h22);
        reg_rd(6, v); chk("R9 idle cancel empties", v, 32'h0);

        // R12 held write request, then read priority
        mover_on = 1'b0;
        reg_wr(4, 32'h300); reg_wr(5, 32'd2); reg_wr(3, 32'h1);
        host_wr(1'b0, 32'h0000BBAA);
        wait_cyc(2);
        reg_wr(1, 32'hA00); reg_wr(2, 32'd2); reg_wr(0, 32'h1);
        wait_cyc(2);
        chk("R12 pending write keeps port", 32'({fl_req, fl_wr}), 32'h3);
        exp_write(32'h300, 8'hAA);
        exp_reads(32'hA00, 2);
        exp_write(32'h301, 8'hBB);
        mover_on = 1'b1;
        wait_done(0, "R12 read");
        wait_done(3, "R12 write");
        chk("R12 order consumed", 32'(expq.size()), 32'd0);
        host_rd(1'b0, v); chk("R5 short word padded", v, wexp(32'hA00, 0, 2));
        reg_wr(0, 32'h20); reg_wr(3, 32'h20);

        // R11 split register
        reg_wr(7, 32'd2);
        reg_rd(7, v); chk("R11 split accepted", v, 32'd2);
        a0 = acks;
        reg_wr(1, 32'hB00); reg_wr(2, 32'd16);
        exp_reads(32'hB00, 8);
        reg_wr(0, 32'h1);
        wait_cyc(30);
        reg_rd(6, v); chk("R11 read share of two words", v, 32'd2);
        chk("R11 bytes before stall", 32'(acks - a0), 32'd8);
        reg_wr(7, 32'd5);
        reg_rd(7, v); chk("R11 split ignored while busy", v, 32'd2);
        reg_wr(0, 32'h2);
        reg_wr(7, 32'd0);
        reg_rd(7, v); chk("R11 zero rejected", v, 32'd2);
        reg_wr(7, 32'd16);
        reg_rd(7, v); chk("R11 full size rejected", v, 32'd2);
        reg_wr(7, 32'd8);
        reg_rd(7, v); chk("R11 split restored", v, 32'd8);
        chk("R3 scoreboard empty at end", 32'(expq.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule